// File: doc/BRIEF.md
# Bus-Master Transfer Control and Interrupt Logic

This block holds the control state of a two-direction FIFO bus-master engine. The inbound direction (called "read") pulls words from the host bus into a local FIFO. The outbound direction (called "write") pushes words from a local FIFO onto the host bus. Software programs the block through a single-cycle register write port. It sets a master enable and a FIFO fill scheme for each direction, one shared switch that turns on transfer counting, the two completion interrupt enables, and a transfer count for each direction.

A bus engine outside this block reports each moved word and any master or target abort. The block returns two request-eligibility signals, which tell that engine when it may ask for the bus. It also drives one interrupt line and a sticky four-bit status vector that software clears by writing ones. Two one-cycle command outputs reset the flags of the inbound and outbound FIFOs.

Register selector values on `regSel` are: 0 control, 1 interrupt, 2 general, 3 read count, 4 write count. A count write takes the low `CNT_W` bits of `regWrData` in one access.

Top module: `bmdma_ctrl`

## Requirements
- R1: Control register (selector 0) bit 14 enables read mastering and bit 10 enables write mastering, each on its own. A direction's request-eligibility output is never high while its enable is clear.
- R2: General register (selector 2) bit 28 turns on counting for both directions together. While it is set, each word strobe of a direction lowers that direction's count by one, and the count stays at zero once it gets there. While it is clear, the counts hold.
- R3: A count write loads the whole count in one cycle, and a count write wins over a strobe in the same cycle. With counting on, a direction is eligible only while its count is non-zero. So with mastering already enabled, writing a non-zero count starts a transfer.
- R4: With counting on, a strobe that takes a count from one to zero sets a sticky completion status bit. intStatus[1] is read complete (register bit 19) and intStatus[0] is write complete (register bit 18).
- R5: masterAbort sets intStatus[2] (bit 20) and targetAbort sets intStatus[3] (bit 21). Either abort clears the master enable of the direction named by abortDir (0 read, 1 write), and that direction stays ineligible until the control register is written again.
- R6: A write to the interrupt register (selector 1) clears each status bit among 21..18 whose data bit is one. Data bits of zero leave the status unchanged. A status event in the same cycle wins over the clear.
- R7: Interrupt register bit 15 enables the read-complete interrupt and bit 14 enables the write-complete interrupt. Both abort interrupts are enabled whenever either of these is set. irq is the OR of the status bits that are set and enabled.
- R8: A general register write with bit 26 set gives a one-cycle inFlagReset pulse in the following cycle. Bit 25 does the same for outFlagReset.
- R9: Control bit 13 selects the read scheme and bit 9 selects the write scheme. Scheme 0 needs at least one free word (read) or one stored word (write). Scheme 1 needs at least FIFO_DEPTH/2 of them.
- R10: After reset all enables, counts, status bits, irq, eligibility outputs and pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register selector |
| regWrData | input | 32 | Register write data |
| rdWordDone | input | 1 | One inbound word moved |
| wrWordDone | input | 1 | One outbound word moved |
| masterAbort | input | 1 | Master abort seen on the bus |
| targetAbort | input | 1 | Target abort seen on the bus |
| abortDir | input | 1 | Direction of the aborted transfer (0 read, 1 write) |
| rdFifoFree | input | LVL_W | Free words in the inbound FIFO |
| wrFifoUsed | input | LVL_W | Stored words in the outbound FIFO |
| rdReqOk | output | 1 | Read direction may request the bus |
| wrReqOk | output | 1 | Write direction may request the bus |
| irq | output | 1 | Interrupt |
| intStatus | output | 4 | Sticky status {target abort, master abort, read done, write done} |
| rdCount | output | CNT_W | Read transfer count |
| wrCount | output | CNT_W | Write transfer count |
| inFlagReset | output | 1 | Inbound FIFO flag reset pulse |
| outFlagReset | output | 1 | Outbound FIFO flag reset pulse |

## Verification
The hardest cases to reach from the ports are collisions in one cycle. These are a last-word strobe that meets a write-one-to-clear of the same status bit, a last-word strobe that meets a new count write, and an abort that meets a control write re-enabling the same direction. Directed sequences first load a count of one and then line up each of these writes with the final strobe. A long random phase follows. It draws small count values so that counts often reach zero, and enables are written often, so collisions like these keep recurring. A behavioural model in the bench checks every output on every cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_IRQ   = 3'd1,
    SEL_GEN   = 3'd2,
    SEL_RDCNT = 3'd3,
    SEL_WRCNT = 3'd4
  } regSel_e;

  localparam int DIR_RD = 0;
  localparam int DIR_WR = 1;

  // control register fields
  localparam int B_RD_MASTER = 14;
  localparam int B_RD_SCHEME = 13;
  localparam int B_WR_MASTER = 10;
  localparam int B_WR_SCHEME = 9;
  // interrupt register fields
  localparam int B_RD_IE     = 15;
  localparam int B_WR_IE     = 14;
  localparam int B_ST_TABORT = 21;
  localparam int B_ST_MABORT = 20;
  localparam int B_ST_RDDONE = 19;
  localparam int B_ST_WRDONE = 18;
  // general register fields
  localparam int B_CNT_EN    = 28;
  localparam int B_IN_FLRST  = 26;
  localparam int B_OUT_FLRST = 25;

  // strobes from control to datapath, index 0 = read, 1 = write
  typedef struct packed {
    logic [1:0] load;
    logic [1:0] dec;
    logic [1:0] scheme;
  } ctlToDp_t;

endpackage

// File: rtl/bmdma_datapath.sv
module bmdma_datapath
  import bmdma_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlToDp_t                    ctl,
  input  logic [CNT_W-1:0]            loadValue,
  input  logic [1:0][LVL_W-1:0]       levels,
  output logic [1:0][CNT_W-1:0]       count,
  output logic [1:0]                  nonZero,
  output logic [1:0]                  done,
  output logic [1:0]                  fifoOk
);

  localparam int HALF = FIFO_DEPTH / 2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [LVL_W-1:0] LVL_HALF = LVL_W'(HALF);

  logic [CNT_W-1:0] cntQ [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[d] <= '0;
      end else if (ctl.load[d]) begin
        cntQ[d] <= loadValue;
      end else if (ctl.dec[d] && (cntQ[d] != '0)) begin
        cntQ[d] <= cntQ[d] - CNT_ONE;
      end
    end

    assign count[d]   = cntQ[d];
    assign nonZero[d] = (cntQ[d] != '0);
    assign done[d]    = ctl.dec[d] && !ctl.load[d] && (cntQ[d] == CNT_ONE);
    assign fifoOk[d]  = ctl.scheme[d] ? (levels[d] >= LVL_HALF)
                                      : (levels[d] != '0);

    // R2: a count at zero stays there unless reloaded
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[d] == '0) && !ctl.load[d] |=> (cntQ[d] == '0));

    // R2: each enabled strobe lowers a non-zero count by exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
      ctl.dec[d] && !ctl.load[d] && (cntQ[d] != '0)
      |=> (cntQ[d] == $past(cntQ[d]) - CNT_ONE));

    // R3: a count write lands in full on the next cycle
    a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
      ctl.load[d] |=> (cntQ[d] == $past(loadValue)));
  end

endmodule

// File: rtl/bmdma_ctl.sv
module bmdma_ctl
  import bmdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              rdWordDone,
  input  logic              wrWordDone,
  input  logic              masterAbort,
  input  logic              targetAbort,
  input  logic              abortDir,
  input  logic [1:0]        dpNonZero,
  input  logic [1:0]        dpDone,
  input  logic [1:0]        dpFifoOk,
  output ctlToDp_t          ctl,
  output logic [CNT_W-1:0]  loadValue,
  output logic              rdReqOk,
  output logic              wrReqOk,
  output logic              irq,
  output logic [3:0]        intStatus,
  output logic              inFlagReset,
  output logic              outFlagReset
);

  logic wrCtrl, wrIrq, wrGen, wrRdCnt, wrWrCnt;
  logic rdMasterEn, wrMasterEn, rdScheme, wrScheme;
  logic rdIe, wrIe, cntEn, abortEn, abortAny;
  logic inFlagQ, outFlagQ;
  logic [3:0] statusQ, setMask, clrMask, enMask;
  logic unusedData;

  assign unusedData = ^regWrData;

  // register decode
  assign wrCtrl  = regWrEn && (regSel == SEL_CTRL);
  assign wrIrq   = regWrEn && (regSel == SEL_IRQ);
  assign wrGen   = regWrEn && (regSel == SEL_GEN);
  assign wrRdCnt = regWrEn && (regSel == SEL_RDCNT);
  assign wrWrCnt = regWrEn && (regSel == SEL_WRCNT);

  assign abortAny = masterAbort || targetAbort;

  // strobes to the datapath
  assign ctl.load[DIR_RD]   = wrRdCnt;
  assign ctl.load[DIR_WR]   = wrWrCnt;
  assign ctl.dec[DIR_RD]    = rdWordDone && cntEn;
  assign ctl.dec[DIR_WR]    = wrWordDone && cntEn;
  assign ctl.scheme[DIR_RD] = rdScheme;
  assign ctl.scheme[DIR_WR] = wrScheme;
  assign loadValue          = regWrData[CNT_W-1:0];

  // enables and command pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdMasterEn <= 1'b0;
      wrMasterEn <= 1'b0;
      rdScheme   <= 1'b0;
      wrScheme   <= 1'b0;
      rdIe       <= 1'b0;
      wrIe       <= 1'b0;
      cntEn      <= 1'b0;
      inFlagQ    <= 1'b0;
      outFlagQ   <= 1'b0;
    end else begin
      inFlagQ  <= wrGen && regWrData[B_IN_FLRST];
      outFlagQ <= wrGen && regWrData[B_OUT_FLRST];
      if (wrCtrl) begin
        rdMasterEn <= regWrData[B_RD_MASTER];
        rdScheme   <= regWrData[B_RD_SCHEME];
        wrMasterEn <= regWrData[B_WR_MASTER];
        wrScheme   <= regWrData[B_WR_SCHEME];
      end
      // an abort overrides a same-cycle re-enable of its direction
      if (abortAny) begin
        if (abortDir) wrMasterEn <= 1'b0;
        else          rdMasterEn <= 1'b0;
      end
      if (wrIrq) begin
        rdIe <= regWrData[B_RD_IE];
        wrIe <= regWrData[B_WR_IE];
      end
      if (wrGen) begin
        cntEn <= regWrData[B_CNT_EN];
      end
    end
  end

  // sticky status: {target abort, master abort, read done, write done}
  assign setMask = {targetAbort, masterAbort, dpDone[DIR_RD], dpDone[DIR_WR]};
  assign clrMask = wrIrq ? {regWrData[B_ST_TABORT], regWrData[B_ST_MABORT],
                            regWrData[B_ST_RDDONE], regWrData[B_ST_WRDONE]}
                         : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= 4'b0000;
    else       statusQ <= (statusQ & ~clrMask) | setMask;
  end

  assign abortEn = rdIe || wrIe;
  assign enMask  = {abortEn, abortEn, rdIe, wrIe};

  assign irq          = |(statusQ & enMask);
  assign intStatus    = statusQ;
  assign inFlagReset  = inFlagQ;
  assign outFlagReset = outFlagQ;

  assign rdReqOk = rdMasterEn && dpFifoOk[DIR_RD] && (!cntEn || dpNonZero[DIR_RD]);
  assign wrReqOk = wrMasterEn && dpFifoOk[DIR_WR] && (!cntEn || dpNonZero[DIR_WR]);

  // R4: a completion reported by the datapath is held in status
  a_r4_rd_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dpDone[DIR_RD] |=> intStatus[1]);
  a_r4_wr_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dpDone[DIR_WR] |=> intStatus[0]);

  // R5: an abort leaves its direction ineligible in the next cycle
  a_r5_abort_stops_rd: assert property (@(posedge clk) disable iff (!rstN)
    abortAny && !abortDir |=> !rdReqOk);
  a_r5_abort_stops_wr: assert property (@(posedge clk) disable iff (!rstN)
    abortAny && abortDir |=> !wrReqOk);

  // R6: a zero data bit in a clear write keeps the status bit
  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    wrIrq && !regWrData[B_ST_RDDONE] && intStatus[1] |=> intStatus[1]);

  // R7: the interrupt line needs a pending status bit
  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intStatus != 4'b0000));

  // R8: a flag reset pulse always follows a general write with its bit set
  a_r8_in_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    inFlagReset |-> $past(wrGen && regWrData[B_IN_FLRST]));
  a_r8_out_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    outFlagReset |-> $past(wrGen && regWrData[B_OUT_FLRST]));

  // R3: with counting on, an exhausted count blocks eligibility
  a_r3_zero_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cntEn && !dpNonZero[DIR_RD] |-> !rdReqOk);

endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              rdWordDone,
  input  logic              wrWordDone,
  input  logic              masterAbort,
  input  logic              targetAbort,
  input  logic              abortDir,
  input  logic [LVL_W-1:0]  rdFifoFree,
  input  logic [LVL_W-1:0]  wrFifoUsed,
  output logic              rdReqOk,
  output logic              wrReqOk,
  output logic              irq,
  output logic [3:0]        intStatus,
  output logic [CNT_W-1:0]  rdCount,
  output logic [CNT_W-1:0]  wrCount,
  output logic              inFlagReset,
  output logic              outFlagReset
);

  ctlToDp_t                  ctlBus;
  logic [CNT_W-1:0]          loadValue;
  logic [1:0][LVL_W-1:0]     levels;
  logic [1:0][CNT_W-1:0]     counts;
  logic [1:0]                nonZero, done, fifoOk;

  assign levels[DIR_RD] = rdFifoFree;
  assign levels[DIR_WR] = wrFifoUsed;
  assign rdCount = counts[DIR_RD];
  assign wrCount = counts[DIR_WR];

  bmdma_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regSel       (regSel),
    .regWrData    (regWrData),
    .rdWordDone   (rdWordDone),
    .wrWordDone   (wrWordDone),
    .masterAbort  (masterAbort),
    .targetAbort  (targetAbort),
    .abortDir     (abortDir),
    .dpNonZero    (nonZero),
    .dpDone       (done),
    .dpFifoOk     (fifoOk),
    .ctl          (ctlBus),
    .loadValue    (loadValue),
    .rdReqOk      (rdReqOk),
    .wrReqOk      (wrReqOk),
    .irq          (irq),
    .intStatus    (intStatus),
    .inFlagReset  (inFlagReset),
    .outFlagReset (outFlagReset)
  );

  bmdma_datapath #(
    .CNT_W      (CNT_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .loadValue (loadValue),
    .levels    (levels),
    .count     (counts),
    .nonZero   (nonZero),
    .done      (done),
    .fifoOk    (fifoOk)
  );

endmodule

// File: tb/bmdma_ctrl_test.sv
module bmdma_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int DEPTH      = 8;
  localparam int LVL_W      = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic rdWordDone = 1'b0, wrWordDone = 1'b0;
  logic masterAbort = 1'b0, targetAbort = 1'b0, abortDir = 1'b0;
  logic [LVL_W-1:0] rdFifoFree = '0, wrFifoUsed = '0;
  logic rdReqOk, wrReqOk, irq, inFlagReset, outFlagReset;
  logic [3:0] intStatus;
  logic [CNT_W-1:0] rdCount, wrCount;

  bmdma_ctrl #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .rdWordDone(rdWordDone), .wrWordDone(wrWordDone),
    .masterAbort(masterAbort), .targetAbort(targetAbort), .abortDir(abortDir),
    .rdFifoFree(rdFifoFree), .wrFifoUsed(wrFifoUsed), .rdReqOk(rdReqOk),
    .wrReqOk(wrReqOk), .irq(irq), .intStatus(intStatus), .rdCount(rdCount),
    .wrCount(wrCount), .inFlagReset(inFlagReset), .outFlagReset(outFlagReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  bit mRdEn, mWrEn, mRdSch, mWrSch, mRdIe, mWrIe, mCntEn, mInP, mOutP;
  int mRdCnt, mWrCnt;
  bit [3:0] mStat;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRdEn = 0; mWrEn = 0; mRdSch = 0; mWrSch = 0; mRdIe = 0; mWrIe = 0;
      mCntEn = 0; mInP = 0; mOutP = 0; mRdCnt = 0; mWrCnt = 0; mStat = 0;
    end else begin
      bit ldR, ldW, dnR, dnW, wC, wI, wG;
      bit [3:0] setM, clrM;
      wC  = regWrEn && regSel == 3'd0;
      wI  = regWrEn && regSel == 3'd1;
      wG  = regWrEn && regSel == 3'd2;
      ldR = regWrEn && regSel == 3'd3;
      ldW = regWrEn && regSel == 3'd4;
      dnR = mCntEn && rdWordDone && !ldR && mRdCnt == 1;
      dnW = mCntEn && wrWordDone && !ldW && mWrCnt == 1;
      if (ldR) mRdCnt = int'(regWrData[15:0]);
      else if (mCntEn && rdWordDone && mRdCnt > 0) mRdCnt = mRdCnt - 1;
      if (ldW) mWrCnt = int'(regWrData[15:0]);
      else if (mCntEn && wrWordDone && mWrCnt > 0) mWrCnt = mWrCnt - 1;
      setM = {targetAbort, masterAbort, dnR, dnW};
      clrM = wI ? {regWrData[21], regWrData[20], regWrData[19], regWrData[18]} : 4'b0;
      mStat = (mStat & ~clrM) | setM;
      if (wC) begin
        mRdEn = regWrData[14]; mRdSch = regWrData[13];
        mWrEn = regWrData[10]; mWrSch = regWrData[9];
      end
      if (masterAbort || targetAbort) begin
        if (abortDir) mWrEn = 0; else mRdEn = 0;
      end
      if (wI) begin mRdIe = regWrData[15]; mWrIe = regWrData[14]; end
      mInP  = wG && regWrData[26];
      mOutP = wG && regWrData[25];
      if (wG) mCntEn = regWrData[28];
    end
  end

  function automatic bit expReq(input bit en, input bit sch, input int lvl, input int cnt);
    bit fifo;
    fifo = sch ? (lvl >= DEPTH/2) : (lvl >= 1);
    return en && fifo && (!mCntEn || cnt != 0);
  endfunction

  // compare every cycle, after the edge and before the next input change
  always @(posedge clk) begin
    #2;
    if (rstN && !finished) begin
      bit eIrq;
      eIrq = (mStat[1] && mRdIe) || (mStat[0] && mWrIe) ||
             ((mStat[3] || mStat[2]) && (mRdIe || mWrIe));
      check(rdCount == CNT_W'(mRdCnt), "R2 R3", "rdCount", int'(rdCount), mRdCnt);
      check(wrCount == CNT_W'(mWrCnt), "R2 R3", "wrCount", int'(wrCount), mWrCnt);
      check(intStatus == mStat, "R4 R5 R6", "intStatus", int'(intStatus), int'(mStat));
      check(irq == eIrq, "R7", "irq", int'(irq), int'(eIrq));
      check(rdReqOk == expReq(mRdEn, mRdSch, int'(rdFifoFree), mRdCnt),
            "R1 R3 R5 R9", "rdReqOk", int'(rdReqOk),
            int'(expReq(mRdEn, mRdSch, int'(rdFifoFree), mRdCnt)));
      check(wrReqOk == expReq(mWrEn, mWrSch, int'(wrFifoUsed), mWrCnt),
            "R1 R3 R5 R9", "wrReqOk", int'(wrReqOk),
            int'(expReq(mWrEn, mWrSch, int'(wrFifoUsed), mWrCnt)));
      check(inFlagReset == mInP, "R8", "inFlagReset", int'(inFlagReset), int'(mInP));
      check(outFlagReset == mOutP, "R8", "outFlagReset", int'(outFlagReset), int'(mOutP));
    end
  end

  task automatic regWr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = s; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({rdReqOk, wrReqOk, irq, inFlagReset, outFlagReset} == 5'b0, "R10",
          "flags in reset", int'({rdReqOk, wrReqOk, irq, inFlagReset, outFlagReset}), 0);
    check(intStatus == 4'b0 && rdCount == '0 && wrCount == '0, "R10",
          "status and counts in reset", int'(intStatus), 0);
    rstN = 1'b1;
    rdFifoFree = LVL_W'(DEPTH); wrFifoUsed = LVL_W'(DEPTH);
    idle(2);
    // R1: independent enables
    regWr(3'd0, 32'h0000_4000); idle(1);
    regWr(3'd0, 32'h0000_0400); idle(1);
    regWr(3'd0, 32'h0000_4400); idle(1);
    // R2 R3: shared count enable, zero counts block, non-zero count starts
    regWr(3'd2, 32'h1000_0000); idle(1);
    regWr(3'd3, 32'd3); regWr(3'd4, 32'd2); idle(1);
    // R4 R7: count down to completion with interrupt on
    regWr(3'd1, 32'h0000_8000);
    @(negedge clk); rdWordDone = 1; wrWordDone = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rdWordDone = 0; wrWordDone = 0;
    idle(2);
    // R6: zero leaves status, one clears
    regWr(3'd1, 32'h0000_8000); idle(1);
    regWr(3'd1, 32'h0008_8000); idle(1);
    // R6: final strobe meets a clear of the same bit
    regWr(3'd3, 32'd1);
    @(negedge clk); rdWordDone = 1; regWrEn = 1; regSel = 3'd1; regWrData = 32'h0008_8000;
    @(negedge clk); rdWordDone = 0; regWrEn = 0; regWrData = '0;
    idle(1);
    // R3: final strobe meets a reload
    regWr(3'd3, 32'd1);
    @(negedge clk); rdWordDone = 1; regWrEn = 1; regSel = 3'd3; regWrData = 32'd5;
    @(negedge clk); rdWordDone = 0; regWrEn = 0; regWrData = '0;
    idle(1);
    // R5: abort meets a re-enable of the same direction
    @(negedge clk); masterAbort = 1; abortDir = 0;
    regWrEn = 1; regSel = 3'd0; regWrData = 32'h0000_4400;
    @(negedge clk); masterAbort = 0; regWrEn = 0; regWrData = '0;
    idle(1);
    @(negedge clk); targetAbort = 1; abortDir = 1;
    @(negedge clk); targetAbort = 0;
    idle(1);
    // R7: interrupt enables off mask pending status
    regWr(3'd1, 32'h0000_0000); idle(1);
    regWr(3'd1, 32'h0000_4000); idle(1);
    // R9: schemes
    regWr(3'd2, 32'h0000_0000);
    regWr(3'd0, 32'h0000_6600);
    for (int l = 0; l <= DEPTH; l++) begin
      @(negedge clk); rdFifoFree = LVL_W'(l); wrFifoUsed = LVL_W'(DEPTH - l);
    end
    regWr(3'd0, 32'h0000_4400);
    for (int l = 0; l <= 2; l++) begin
      @(negedge clk); rdFifoFree = LVL_W'(l); wrFifoUsed = LVL_W'(l);
    end
    // R8: flag reset pulses
    regWr(3'd2, 32'h0400_0000); idle(1);
    regWr(3'd2, 32'h0200_0000); idle(1);
    regWr(3'd2, 32'h0600_0000); idle(2);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int s;
      @(negedge clk);
      s = $urandom_range(0, 4);
      regWrEn = ($urandom_range(0, 3) == 0);
      regSel = 3'(s);
      regWrData = $urandom;
      if (s >= 3) regWrData = 32'($urandom_range(0, 4));
      if (s == 0 && $urandom_range(0, 1) == 1) regWrData = regWrData | 32'h0000_4400;
      if (s == 2 && $urandom_range(0, 1) == 1) regWrData = regWrData | 32'h1000_0000;
      rdWordDone = $urandom_range(0, 1) == 1;
      wrWordDone = $urandom_range(0, 1) == 1;
      masterAbort = ($urandom_range(0, 63) == 0);
      targetAbort = ($urandom_range(0, 63) == 0);
      abortDir = $urandom_range(0, 1) == 1;
      rdFifoFree = LVL_W'($urandom_range(0, DEPTH));
      wrFifoUsed = LVL_W'($urandom_range(0, DEPTH));
    end
    @(negedge clk);
    regWrEn = 0; rdWordDone = 0; wrWordDone = 0; masterAbort = 0; targetAbort = 0;
    idle(3);
    finishRun();
  end

endmodule